// File: doc/BRIEF.md
# Fractional Clock Divider with Noise Shaping

This block derives a bit clock from one of eight source clocks. Each source is modelled as a one-cycle tick on the system clock, and a multiplexer picks one of them. The divisor has a 12-bit integer part and a 12-bit fraction. In integer mode every output period lasts exactly the integer number of source ticks. In first-order mode a 12-bit phase accumulator adds the fraction once per output period. A carry out of the accumulator stretches that period by one tick, so the long-run divide ratio is the integer plus the fraction over 4096.

Software programs the block through two 32-bit registers, one for control and one for the divisor. A write lands only if its top byte carries the password value. Stopping is either graceful or immediate. When enable is cleared, the busy flag stays up until the output period in progress has finished, and the output is left low. Setting kill halts the generator at once. While busy is set, the source selection, the mode and the divisor are frozen, so software polls busy before it reprograms them.

Top module: `frac_clk_div`

## Requirements
- R1: After reset both readback registers are zero, busy is low and `clk_o` is low.
- R2: A write whose data bits 31:24 differ from 0x5A changes neither register.
- R3: The control readback places the source in bits 3:0, enable in bit 4, kill in bit 5, busy in bit 7, flip in bit 8 and mode in bits 10:9. The divisor readback places the integer in bits 23:12 and the fraction in bits 11:0. All other bits read zero. `wr_sel_i` = 0 addresses control and 1 addresses the divisor.
- R4: In mode 0 each output period lasts the integer part in selected-source ticks and the fraction is ignored. The output is high for the first floor(L/2) ticks of a period of L ticks. The output register updates on the system clock edge at which the tick is sampled.
- R5: In modes 1, 2 and 3 the accumulator is cleared at start and then gains the fraction at each period start. A period whose addition carries past 4095 lasts integer+1 ticks and every other period lasts integer ticks.
- R6: An integer part of 0 or 1 divides as 2.
- R7: From idle, with enable set and kill clear, the first selected tick sets busy and drives the output high on the same edge.
- R8: After enable is cleared, busy stays set until the final tick of the period in progress. On that tick busy clears and the output goes low.
- R9: On the edge after kill is set, busy is low and the output is low. Both stay low for as long as kill remains set.
- R10: Source 0 and sources 8 to 15 give no ticks. With enable set, busy stays low and the output stays low.
- R11: While busy is set, a passworded write leaves the source, the mode and the whole divisor register unchanged, but it still updates enable, kill and flip.
- R12: `clk_o` is the generator output inverted whenever flip is set, including while the generator is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = control register, 1 = divisor register |
| wr_data_i | input | 32 | Write data; bits 31:24 carry the password |
| src_tick_i | input | NUM_SRC | One-cycle tick per source clock; index 0 is ground |
| ctrl_rdata_o | output | 32 | Control readback including busy |
| div_rdata_o | output | 32 | Divisor readback |
| clk_o | output | 1 | Divided bit clock |

## Verification
The hardest conditions to reach are a kill or an enable clear that lands in the middle of a period, and reprogramming attempts made while the register lock is active. The stimulus reaches them by issuing writes at arbitrary points of a running clock. One source ticks on an irregular pseudo-random pattern, so stop requests fall at scattered phases. A behavioural period model runs alongside the design and is compared on every cycle. Directed edge-to-edge measurements confirm the average fractional ratio, the minimum divisor, and the quiet output on ground sources.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int          DATA_W   = 32;
  localparam logic [7:0]  PW_VAL   = 8'h5A;
  localparam int          PW_LSB   = 24;
  localparam int          SRC_W    = 4;
  localparam int          B_EN     = 4;
  localparam int          B_KILL   = 5;
  localparam int          B_BUSY   = 7;
  localparam int          B_FLIP   = 8;
  localparam int          B_MODE   = 9;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_DIV = 1'b1} reg_sel_e;

  typedef struct packed {
    logic [1:0]       mode;
    logic             flip;
    logic             kill;
    logic             en;
    logic [SRC_W-1:0] src;
  } ctrl_t;
endpackage

// File: rtl/fcd_regs.sv
module fcd_regs
  import fcd_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output ctrl_t             ctrl_o,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o
);
  ctrl_t             ctrl_q;
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic              pw_ok;

  assign pw_ok = wr_en_i && (wr_data_i[PW_LSB +: 8] == PW_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      int_q  <= '0;
      frac_q <= '0;
    end else if (pw_ok) begin
      if (wr_sel_i == SEL_CTRL) begin
        ctrl_q.en   <= wr_data_i[B_EN];
        ctrl_q.kill <= wr_data_i[B_KILL];
        ctrl_q.flip <= wr_data_i[B_FLIP];
        if (!busy_i) begin
          ctrl_q.src  <= wr_data_i[SRC_W-1:0];
          ctrl_q.mode <= wr_data_i[B_MODE +: 2];
        end
      end else if (!busy_i) begin
        int_q  <= wr_data_i[FRAC_W +: INT_W];
        frac_q <= wr_data_i[FRAC_W-1:0];
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign int_o  = int_q;
  assign frac_o = frac_q;

  assert_pw_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[PW_LSB +: 8] != PW_VAL) |=> $stable({ctrl_q, int_q, frac_q}));

  assert_lock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_en_i) |=> $stable({ctrl_q.src, ctrl_q.mode, int_q, frac_q}));
endmodule

// File: rtl/fcd_src_mux.sv
module fcd_src_mux
  import fcd_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] ticks_i,
  output logic               tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (sel_i == SRC_W'(i)) tick_o = ticks_i[i];
    end
  end

  always_comb begin
    if (rst_ni && sel_i == '0) assert_ground_R10: assert (tick_o == 1'b0);
  end
endmodule

// File: rtl/fcd_gen.sv
module fcd_gen #(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              kill_i,
  input  logic              fo_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              busy_o,
  output logic              out_o
);
  localparam int CNT_W = INT_W + 1;

  logic              busy_q, out_q;
  logic [CNT_W-1:0]  cnt_q, len_q, int_eff, len_next, cnt_inc;
  logic [FRAC_W-1:0] acc_q, acc_next;
  logic [FRAC_W:0]   sum;
  logic              last;

  assign int_eff  = (int_i < INT_W'(2)) ? CNT_W'(2) : {1'b0, int_i};
  assign sum      = {1'b0, acc_q} + {1'b0, frac_i};
  assign len_next = int_eff + ((fo_i && sum[FRAC_W]) ? CNT_W'(1) : CNT_W'(0));
  assign acc_next = fo_i ? sum[FRAC_W-1:0] : acc_q;
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign last     = (cnt_q == len_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      out_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
      acc_q  <= '0;
    end else if (kill_i) begin
      busy_q <= 1'b0;
      out_q  <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (tick_i) begin
      if (!busy_q) begin
        if (en_i) begin
          // first period: accumulator starts from zero, no carry possible
          busy_q <= 1'b1;
          out_q  <= 1'b1;
          cnt_q  <= '0;
          len_q  <= int_eff;
          acc_q  <= fo_i ? frac_i : '0;
        end
      end else if (last) begin
        cnt_q <= '0;
        if (en_i) begin
          out_q <= 1'b1;
          len_q <= len_next;
          acc_q <= acc_next;
        end else begin
          busy_q <= 1'b0;
          out_q  <= 1'b0;
          acc_q  <= '0;
        end
      end else begin
        cnt_q <= cnt_inc;
        out_q <= (cnt_inc < (len_q >> 1));
      end
    end
  end

  assign busy_o = busy_q;
  assign out_o  = out_q;

  assert_kill_halts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (!busy_q && !out_q));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !out_q);

  assert_len_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (len_q >= CNT_W'(2) && len_q <= int_eff + CNT_W'(1)));

  assert_busy_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(tick_i && en_i && !kill_i));

  assert_clean_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_q) && !$past(kill_i)) |-> $past(tick_i && !en_i && last));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fcd_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int INT_W   = 12,
  parameter int FRAC_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [31:0]        wr_data_i,
  input  logic [NUM_SRC-1:0] src_tick_i,
  output logic [31:0]        ctrl_rdata_o,
  output logic [31:0]        div_rdata_o,
  output logic               clk_o
);
  localparam int DIV_USED = INT_W + FRAC_W;

  ctrl_t             ctrl;
  logic [INT_W-1:0]  int_val;
  logic [FRAC_W-1:0] frac_val;
  logic              tick, busy, gen_out;

  fcd_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .busy_i   (busy),
    .ctrl_o   (ctrl),
    .int_o    (int_val),
    .frac_o   (frac_val)
  );

  fcd_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .rst_ni (rst_ni),
    .sel_i  (ctrl.src),
    .ticks_i(src_tick_i),
    .tick_o (tick)
  );

  fcd_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_gen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .en_i  (ctrl.en),
    .kill_i(ctrl.kill),
    .fo_i  (ctrl.mode != 2'b00),
    .int_i (int_val),
    .frac_i(frac_val),
    .busy_o(busy),
    .out_o (gen_out)
  );

  always_comb begin
    ctrl_rdata_o = '0;
    ctrl_rdata_o[SRC_W-1:0]   = ctrl.src;
    ctrl_rdata_o[B_EN]        = ctrl.en;
    ctrl_rdata_o[B_KILL]      = ctrl.kill;
    ctrl_rdata_o[B_BUSY]      = busy;
    ctrl_rdata_o[B_FLIP]      = ctrl.flip;
    ctrl_rdata_o[B_MODE +: 2] = ctrl.mode;
  end

  assign div_rdata_o = 32'({int_val, frac_val});
  assign clk_o       = gen_out ^ ctrl.flip;

  assert_flip_out_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !ctrl.kill) |-> (clk_o == ctrl.flip));

  assert_div_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_rdata_o[31:DIV_USED] == '0);
endmodule

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  ticks = '0;
  logic [31:0] ctrl_rd, div_rd;
  logic        clk_out;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  frac_clk_div u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .src_tick_i(ticks),
    .ctrl_rdata_o(ctrl_rd), .div_rdata_o(div_rd), .clk_o(clk_out)
  );

  // source tick patterns
  int tcnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    tcnt++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ticks[0] = 1'b1;
    ticks[1] = 1'b1;
    ticks[2] = (tcnt % 3 == 0);
    ticks[3] = lfsr[0];
    for (int i = 4; i < 8; i++) ticks[i] = tcnt[0];
  end

  // behavioural reference model
  int m_src, m_en, m_kill, m_flip, m_mode, m_int, m_frac;
  int m_busy, m_pos, m_len, m_acc, m_out;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_en = 0; m_kill = 0; m_flip = 0; m_mode = 0; m_int = 0; m_frac = 0;
      m_busy = 0; m_pos = 0; m_len = 0; m_acc = 0; m_out = 0;
    end else begin
      int ob, tk, eff, a2;
      ob = m_busy;
      tk = (m_src >= 1 && m_src < 8) ? int'(ticks[m_src]) : 0;
      eff = (m_int < 2) ? 2 : m_int;
      if (m_kill) begin
        m_busy = 0; m_out = 0; m_pos = 0; m_acc = 0;
      end else if (tk) begin
        if (!m_busy) begin
          if (m_en) begin
            m_busy = 1; m_out = 1; m_pos = 0; m_len = eff;
            m_acc = (m_mode != 0) ? m_frac : 0;
          end
        end else if (m_pos == m_len - 1) begin
          m_pos = 0;
          if (m_en) begin
            a2 = m_acc + ((m_mode != 0) ? m_frac : 0);
            m_len = eff + ((a2 >= 4096) ? 1 : 0);
            m_acc = a2 % 4096;
            m_out = 1;
          end else begin
            m_busy = 0; m_out = 0; m_acc = 0;
          end
        end else begin
          m_pos++;
          m_out = (m_pos < m_len / 2) ? 1 : 0;
        end
      end
      if (wr_en && wr_data[31:24] == 8'h5A) begin
        if (!wr_sel) begin
          m_en = wr_data[4]; m_kill = wr_data[5]; m_flip = wr_data[8];
          if (!ob) begin m_src = wr_data[3:0]; m_mode = wr_data[10:9]; end
        end else if (!ob) begin
          m_int = wr_data[23:12]; m_frac = wr_data[11:0];
        end
      end
    end
  end

  function automatic logic [31:0] exp_ctrl();
    return 32'((m_mode << 9) | (m_flip << 8) | (m_busy << 7) | (m_kill << 5) | (m_en << 4) | m_src);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "clk_o", clk_out, (m_out ^ m_flip));
      chk(cur_req, "ctrl_rdata(R3)", ctrl_rd, exp_ctrl());
      chk(cur_req, "div_rdata(R3)", div_rd, 32'((m_int << 12) | m_frac));
    end
  end

  task automatic wr(input bit sel, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] cw(input int src, input int en, input int kill, input int flip, input int mode);
    return 32'h5A00_0000 | 32'((mode << 9) | (flip << 8) | (kill << 5) | (en << 4) | src);
  endfunction

  task automatic gap(input int n, output int cyc);
    int seen = 0;
    logic prev;
    cyc = 0;
    @(negedge clk); prev = clk_out;
    while (seen < n + 1) begin
      @(negedge clk);
      if (seen > 0) cyc++;
      if (clk_out && !prev) seen++;
      prev = clk_out;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (ctrl_rd[7]) @(negedge clk);
  endtask

  initial begin
    int g;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ctrl after reset", ctrl_rd, 0);
    chk("R1", "div after reset", div_rd, 0);
    chk("R1", "clk_o after reset", clk_out, 0);

    cur_req = "R2";
    wr(0, 32'h5B00_0011);
    wr(1, 32'h0000_4800);
    repeat (5) @(negedge clk);
    chk("R2", "ctrl without password", ctrl_rd, 0);
    chk("R2", "div without password", div_rd, 0);
    chk("R2", "clk_o without password", clk_out, 0);

    cur_req = "R4";
    wr(1, 32'h5A00_4800);
    wr(0, cw(1, 1, 0, 0, 0));
    repeat (6) @(negedge clk);
    chk("R3", "ctrl layout busy/en/src", ctrl_rd, 32'h91);
    chk("R3", "div layout int/frac", div_rd, 32'h0000_4800);
    gap(4, g);
    chk("R4", "mode0 four periods int=4", g, 16);

    cur_req = "R11";
    wr(1, 32'h5A00_6000);
    wr(0, cw(2, 1, 0, 0, 2));
    repeat (3) @(negedge clk);
    chk("R11", "div locked while busy", div_rd, 32'h0000_4800);
    chk("R11", "src/mode locked while busy", ctrl_rd & 32'h60F, 32'h1);

    cur_req = "R8";
    repeat (2) @(posedge clk);
    wr(0, cw(1, 0, 0, 0, 0));
    wait_idle();
    chk("R8", "clk_o low after clean stop", clk_out, 0);

    cur_req = "R5";
    wr(1, 32'h5A00_3400);
    wr(0, cw(1, 1, 0, 0, 1));
    gap(8, g);
    chk("R5", "mode1 eight periods int=3 frac=1/4", g, 26);
    wr(0, cw(1, 0, 0, 0, 1));
    wait_idle();

    cur_req = "R6";
    wr(1, 32'h5A00_1FFF);
    wr(0, cw(2, 1, 0, 0, 0));
    gap(3, g);
    chk("R6", "int=1 divides by 2 (src every 3rd)", g, 18);
    wr(0, cw(2, 0, 0, 0, 0));
    wait_idle();
    wr(1, 32'h5A00_0000);
    wr(0, cw(1, 1, 0, 0, 0));
    gap(2, g);
    chk("R6", "int=0 divides by 2", g, 4);
    wr(0, cw(1, 0, 0, 0, 0));
    wait_idle();

    cur_req = "R7";
    wr(1, 32'h5A00_5000);
    wr(0, cw(2, 1, 0, 0, 0));
    @(negedge clk);
    while (!ctrl_rd[7]) @(negedge clk);
    chk("R7", "clk_o high with first busy cycle", clk_out, 1);

    cur_req = "R12";
    wr(0, cw(2, 1, 0, 1, 0));
    repeat (30) @(negedge clk);
    wr(0, cw(2, 0, 0, 1, 0));
    wait_idle();
    chk("R12", "idle output inverted by flip", clk_out, 1);
    wr(0, cw(2, 0, 0, 0, 0));

    cur_req = "R9";
    wr(1, 32'h5A00_8000);
    wr(0, cw(1, 1, 0, 0, 0));
    repeat (13) @(negedge clk);
    wr(0, cw(1, 1, 1, 0, 0));
    @(negedge clk); @(negedge clk);
    chk("R9", "busy low after kill", ctrl_rd[7], 0);
    chk("R9", "clk_o low after kill", clk_out, 0);
    repeat (20) @(negedge clk);
    chk("R9", "busy stays low while kill held", ctrl_rd[7], 0);
    wr(0, cw(1, 0, 0, 0, 0));

    cur_req = "R10";
    wr(0, cw(0, 1, 0, 0, 0));
    repeat (30) @(negedge clk);
    chk("R10", "ground src busy", ctrl_rd[7], 0);
    chk("R10", "ground src clk_o", clk_out, 0);
    wr(0, cw(0, 0, 0, 0, 0));
    wr(0, cw(9, 1, 0, 0, 0));
    repeat (30) @(negedge clk);
    chk("R10", "src 9 busy", ctrl_rd[7], 0);
    chk("R10", "src 9 clk_o", clk_out, 0);
    wr(0, cw(9, 0, 0, 0, 0));

    cur_req = "R5";
    wr(1, 32'h5A00_5ABC);
    wr(0, cw(3, 1, 0, 0, 3));
    repeat (300) @(negedge clk);
    cur_req = "R8";
    wr(0, cw(3, 0, 0, 0, 3));
    wait_idle();
    repeat (5) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule